// File: doc/BRIEF.md
# Interrupt Controller Host Command Interface

This block is the host-side programming port of an eight-input interrupt controller. The host reaches it with byte reads and writes through two ports, selected by one address bit (even or odd). Chip-select, read and write strobes qualify each access. The command words share these two ports. Which register a write reaches depends on the address bit, on data bits 4 and 3, and on how far the multi-step setup has got.

The block steps through the setup words. It holds the setup state:
- vector base
- cascade word
- trigger mode
- vector spacing
- processor mode
- automatic end-of-interrupt
- buffering
- nesting options

After setup it turns run-time words into three kinds of action:
- mask updates
- one-cycle end-of-interrupt command pulses, which carry a level
- read-register, poll and special-mask selections

The pending-request and in-service vectors arrive as plain inputs. Priority resolution, the acknowledge cycle and the cascade bus belong to neighbouring logic.

Top module: `pic_host_if`

## Requirements
- R1: After reset the following hold: `init_done` is 0, all setup outputs are 0, `imr` is 0, `smm` is 0, `cmd_valid` is 0, and even-port reads return `irr`.
- R2: A write to the even port with data bit 4 set is a start word. In any state it restarts setup and drops `init_done`. It clears `imr`, the vector base, the cascade word and all start-word-4 options. It also returns the read selection to `irr`, turns `smm` off and cancels any pending poll.
- R3: The start word latches four options. Bit 0 means a fourth setup word will follow. Bit 1 set gives `single_mode` = 1. Bit 2 gives `spacing4`. Bit 3 gives `trig_level` (1 = level, 0 = edge).
- R4: After a start word, the next odd write loads `vec_base`. An odd write to `cascade_word` follows only when `single_mode` is 0. A fourth odd write follows only when start-word bit 0 was 1. `init_done` rises on the edge that takes the last required word.
- R5: In the fourth setup word, bit 0 drives `mode_8086`, bit 1 `auto_eoi`, bit 2 `buf_master`, bit 3 `buf_mode` and bit 4 `nested_mode`. When that word is skipped, all five stay 0.
- R6: While `init_done` is 0, the following writes have no effect: even writes with bit 4 clear, and odd writes made before any start word. A run-time-looking even write during setup does not use up a setup step.
- R7: Once `init_done` is 1, every odd write loads `imr`, where a 1 disables that input.
- R8: Once setup is done, an even write with bits 4 and 3 clear is a command word. In the cycle after the write, `cmd_valid` is 1 for one cycle. `cmd_level` carries bits 2:0, `cmd_eoi` bit 5, `cmd_specific` bit 6 and `cmd_rotate` bit 7.
- R9: Once setup is done, an even write with bit 4 clear and bit 3 set is a mode word. If its bit 1 is 1, bit 0 selects what even reads return: 1 gives `isr`, 0 gives `irr`. If bit 1 is 0, the selection is kept.
- R10: In a mode word, bit 6 set loads `smm` from bit 5. When bit 6 is clear, `smm` is kept.
- R11: An odd read returns `imr` in all cases. An even read returns the selected `irr` or `isr`.
- R12: Mode-word bit 2 arms a poll. The next even read returns bit 7 = 1 if `irr & ~imr` is nonzero, with bits 2:0 holding the lowest-numbered such input (input 0 has the highest priority) and bits 6:3 at 0. That read disarms the poll. Odd reads leave the poll armed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs | input | 1 | Chip select |
| wr | input | 1 | Write strobe (one write per cycle) |
| rd | input | 1 | Read strobe |
| a0 | input | 1 | Port address: 0 even, 1 odd |
| din | input | 8 | Write data |
| irr | input | 8 | Pending request vector |
| isr | input | 8 | In-service vector |
| dout | output | 8 | Read data (combinational) |
| init_done | output | 1 | Setup complete |
| vec_base | output | 8 | Vector base |
| cascade_word | output | 8 | Cascade word (slave map or identifier) |
| trig_level | output | 1 | Level-triggered inputs |
| spacing4 | output | 1 | Four-byte vector spacing |
| single_mode | output | 1 | No cascade |
| mode_8086 | output | 1 | 8086 processor mode |
| auto_eoi | output | 1 | Automatic end of interrupt |
| buf_master | output | 1 | Buffered role is master |
| buf_mode | output | 1 | Buffered mode |
| nested_mode | output | 1 | Special fully nested mode |
| imr | output | 8 | Interrupt mask |
| smm | output | 1 | Special mask mode |
| cmd_valid | output | 1 | Command pulse |
| cmd_rotate | output | 1 | Rotate flag of the pulse |
| cmd_specific | output | 1 | Specific-level flag of the pulse |
| cmd_eoi | output | 1 | End-of-interrupt flag of the pulse |
| cmd_level | output | 3 | Level of the pulse |

## Verification
The bench walks all four setup paths: single with and without the fourth word, and cascaded with and without it. A sequencer that skips or adds a step would load the vector base or the cascade word from the wrong write, or would raise `init_done` early or late. It restarts setup midway and after completion. A restart that fails to clear state would leave a stale vector base or mask in place. It sends run-time words before setup ends, where a loose decoder would fire commands or eat a setup step. It also checks that mode words without their enable bits keep the prior selection. Poll tests mask the highest-priority request and interleave odd reads. A wrong priority or a poll that an odd read disarms would show up as a bad poll byte.

// File: rtl/pic_host_pkg.sv
package pic_host_pkg;
  localparam int DATA_W = 8;
  localparam int LVL_W  = $clog2(DATA_W);

  typedef enum logic [2:0] {
    SEQ_IDLE, SEQ_NEED2, SEQ_NEED3, SEQ_NEED4, SEQ_READY
  } seq_t;

  typedef enum logic [2:0] {
    WK_NONE, WK_ICW1, WK_ICW2, WK_ICW3, WK_ICW4, WK_OCW1, WK_OCW2, WK_OCW3
  } wkind_t;

  // Which register a write reaches: port, bits 4/3 and sequencer state.
  function automatic wkind_t classify(input logic odd, input logic [DATA_W-1:0] d,
                                      input seq_t st);
    wkind_t k;
    k = WK_NONE;
    if (!odd) begin
      if (d[4])                 k = WK_ICW1;
      else if (st == SEQ_READY) k = d[3] ? WK_OCW3 : WK_OCW2;
    end else begin
      case (st)
        SEQ_NEED2: k = WK_ICW2;
        SEQ_NEED3: k = WK_ICW3;
        SEQ_NEED4: k = WK_ICW4;
        SEQ_READY: k = WK_OCW1;
        default:   k = WK_NONE;
      endcase
    end
    return k;
  endfunction

  function automatic seq_t after_icw2(input logic single, input logic need4);
    if (!single) return SEQ_NEED3;
    return need4 ? SEQ_NEED4 : SEQ_READY;
  endfunction

  function automatic seq_t after_icw3(input logic need4);
    return need4 ? SEQ_NEED4 : SEQ_READY;
  endfunction

  // Poll byte: bit 7 = any pending, low bits = lowest-numbered pending input.
  function automatic logic [DATA_W-1:0] poll_byte(input logic [DATA_W-1:0] pend);
    logic [DATA_W-1:0] r;
    r = '0;
    for (int i = DATA_W - 1; i >= 0; i--) begin
      if (pend[i]) begin
        r = '0;
        r[DATA_W-1] = 1'b1;
        r[LVL_W-1:0] = LVL_W'(i);
      end
    end
    return r;
  endfunction
endpackage

// File: rtl/pic_cmd_decode.sv
module pic_cmd_decode
  import pic_host_pkg::*;
(
  input  logic              wr_stb,
  input  logic              odd,
  input  logic [DATA_W-1:0] d,
  input  seq_t              st,
  output wkind_t            kind
);
  always_comb kind = wr_stb ? classify(odd, d, st) : WK_NONE;
endmodule

// File: rtl/pic_init_seq.sv
module pic_init_seq
  import pic_host_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  wkind_t            kind,
  input  logic [DATA_W-1:0] d,
  output seq_t              st,
  output logic [DATA_W-1:0] vec_base,
  output logic [DATA_W-1:0] cascade_word,
  output logic              trig_level,
  output logic              spacing4,
  output logic              single_mode,
  output logic              mode_8086,
  output logic              auto_eoi,
  output logic              buf_master,
  output logic              buf_mode,
  output logic              nested_mode
);
  logic need4;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= SEQ_IDLE;
      need4 <= 1'b0;
      vec_base <= '0;
      cascade_word <= '0;
      {trig_level, spacing4, single_mode} <= '0;
      {nested_mode, buf_mode, buf_master, auto_eoi, mode_8086} <= '0;
    end else begin
      case (kind)
        WK_ICW1: begin
          st <= SEQ_NEED2;
          need4 <= d[0];
          single_mode <= d[1];
          spacing4 <= d[2];
          trig_level <= d[3];
          vec_base <= '0;
          cascade_word <= '0;
          {nested_mode, buf_mode, buf_master, auto_eoi, mode_8086} <= '0;
        end
        WK_ICW2: begin
          vec_base <= d;
          st <= after_icw2(single_mode, need4);
        end
        WK_ICW3: begin
          cascade_word <= d;
          st <= after_icw3(need4);
        end
        WK_ICW4: begin
          {nested_mode, buf_mode, buf_master, auto_eoi, mode_8086} <= d[4:0];
          st <= SEQ_READY;
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/pic_op_regs.sv
module pic_op_regs
  import pic_host_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  wkind_t            kind,
  input  logic [DATA_W-1:0] d,
  input  logic              rd_even,
  output logic [DATA_W-1:0] imr,
  output logic              read_isr,
  output logic              smm,
  output logic              poll_armed,
  output logic              cmd_valid,
  output logic              cmd_rotate,
  output logic              cmd_specific,
  output logic              cmd_eoi,
  output logic [LVL_W-1:0]  cmd_level
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      imr <= '0;
      read_isr <= 1'b0;
      smm <= 1'b0;
      poll_armed <= 1'b0;
      cmd_valid <= 1'b0;
      {cmd_rotate, cmd_specific, cmd_eoi} <= '0;
      cmd_level <= '0;
    end else begin
      cmd_valid <= 1'b0;
      if (rd_even) poll_armed <= 1'b0;
      case (kind)
        WK_ICW1: begin
          imr <= '0;
          read_isr <= 1'b0;
          smm <= 1'b0;
          poll_armed <= 1'b0;
        end
        WK_OCW1: imr <= d;
        WK_OCW2: begin
          cmd_valid <= 1'b1;
          cmd_rotate <= d[7];
          cmd_specific <= d[6];
          cmd_eoi <= d[5];
          cmd_level <= d[LVL_W-1:0];
        end
        WK_OCW3: begin
          if (d[1]) read_isr <= d[0];
          if (d[6]) smm <= d[5];
          if (d[2]) poll_armed <= 1'b1;
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/pic_read_mux.sv
module pic_read_mux
  import pic_host_pkg::*;
(
  input  logic              odd,
  input  logic              poll_armed,
  input  logic              read_isr,
  input  logic [DATA_W-1:0] irr,
  input  logic [DATA_W-1:0] isr,
  input  logic [DATA_W-1:0] imr,
  output logic [DATA_W-1:0] dout
);
  always_comb begin
    if (odd)             dout = imr;
    else if (poll_armed) dout = poll_byte(irr & ~imr);
    else if (read_isr)   dout = isr;
    else                 dout = irr;
  end
endmodule

// File: rtl/pic_host_if.sv
module pic_host_if
  import pic_host_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs,
  input  logic              wr,
  input  logic              rd,
  input  logic              a0,
  input  logic [DATA_W-1:0] din,
  input  logic [DATA_W-1:0] irr,
  input  logic [DATA_W-1:0] isr,
  output logic [DATA_W-1:0] dout,
  output logic              init_done,
  output logic [DATA_W-1:0] vec_base,
  output logic [DATA_W-1:0] cascade_word,
  output logic              trig_level,
  output logic              spacing4,
  output logic              single_mode,
  output logic              mode_8086,
  output logic              auto_eoi,
  output logic              buf_master,
  output logic              buf_mode,
  output logic              nested_mode,
  output logic [DATA_W-1:0] imr,
  output logic              smm,
  output logic              cmd_valid,
  output logic              cmd_rotate,
  output logic              cmd_specific,
  output logic              cmd_eoi,
  output logic [LVL_W-1:0]  cmd_level
);
  seq_t   st;
  wkind_t kind;
  logic   wr_stb, rd_even, read_isr, poll_armed;

  assign wr_stb  = cs & wr;
  assign rd_even = cs & rd & ~a0;
  assign init_done = (st == SEQ_READY);

  pic_cmd_decode u_dec (
    .wr_stb(wr_stb), .odd(a0), .d(din), .st(st), .kind(kind)
  );

  pic_init_seq u_seq (
    .clk(clk), .rst_n(rst_n), .kind(kind), .d(din), .st(st),
    .vec_base(vec_base), .cascade_word(cascade_word), .trig_level(trig_level),
    .spacing4(spacing4), .single_mode(single_mode), .mode_8086(mode_8086),
    .auto_eoi(auto_eoi), .buf_master(buf_master), .buf_mode(buf_mode),
    .nested_mode(nested_mode)
  );

  pic_op_regs u_ops (
    .clk(clk), .rst_n(rst_n), .kind(kind), .d(din), .rd_even(rd_even),
    .imr(imr), .read_isr(read_isr), .smm(smm), .poll_armed(poll_armed),
    .cmd_valid(cmd_valid), .cmd_rotate(cmd_rotate), .cmd_specific(cmd_specific),
    .cmd_eoi(cmd_eoi), .cmd_level(cmd_level)
  );

  pic_read_mux u_rmux (
    .odd(a0), .poll_armed(poll_armed), .read_isr(read_isr),
    .irr(irr), .isr(isr), .imr(imr), .dout(dout)
  );
endmodule

// File: rtl/pic_host_checker.sv
module pic_host_checker
  import pic_host_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              cs,
  input logic              wr,
  input logic              rd,
  input logic              a0,
  input logic [DATA_W-1:0] din,
  input logic [DATA_W-1:0] dout,
  input logic              init_done,
  input logic              single_mode,
  input logic [DATA_W-1:0] imr,
  input logic              smm,
  input logic              cmd_valid
);
  logic start_wr, odd_wr, mode_wr, cmd_wr;
  assign start_wr = cs && wr && !a0 && din[4];
  assign odd_wr   = cs && wr && a0;
  assign mode_wr  = cs && wr && !a0 && !din[4] && din[3];
  assign cmd_wr   = cs && wr && !a0 && !din[4] && !din[3];

  p_restart_r2: assert property (@(posedge clk) disable iff (!rst_n)
    start_wr |=> (!init_done && imr == '0 && !smm));

  p_single_bit_r3: assert property (@(posedge clk) disable iff (!rst_n)
    start_wr |=> (single_mode == $past(din[1])));

  p_no_cmd_uninit_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_wr && !init_done) |=> !cmd_valid);

  p_mask_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !(odd_wr && init_done) && !start_wr |=> $stable(imr));

  p_cmd_source_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_wr && init_done) |=> cmd_valid);

  p_smm_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !start_wr && !(mode_wr && init_done && din[6]) |=> $stable(smm));

  p_odd_read_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (cs && rd && a0) |-> (dout == imr));
endmodule

bind pic_host_if pic_host_checker u_chk (
  .clk(clk), .rst_n(rst_n), .cs(cs), .wr(wr), .rd(rd), .a0(a0), .din(din),
  .dout(dout), .init_done(init_done), .single_mode(single_mode), .imr(imr),
  .smm(smm), .cmd_valid(cmd_valid)
);

// File: tb/pic_host_if_bench.sv
`timescale 1ns/1ps
module pic_host_if_bench;
  logic clk = 1'b0, rst_n = 1'b0;
  logic cs = 0, wr = 0, rd = 0, a0 = 0;
  logic [7:0] din = 0, irr = 0, isr = 0;
  logic [7:0] dout, vec_base, cascade_word, imr;
  logic init_done, trig_level, spacing4, single_mode, mode_8086, auto_eoi;
  logic buf_master, buf_mode, nested_mode, smm;
  logic cmd_valid, cmd_rotate, cmd_specific, cmd_eoi;
  logic [2:0] cmd_level;
  int checks = 0, failures = 0;
  bit done = 0;

  always #10 clk = ~clk;

  pic_host_if u_pic_host_if (
    .clk(clk), .rst_n(rst_n), .cs(cs), .wr(wr), .rd(rd), .a0(a0), .din(din),
    .irr(irr), .isr(isr), .dout(dout), .init_done(init_done), .vec_base(vec_base),
    .cascade_word(cascade_word), .trig_level(trig_level), .spacing4(spacing4),
    .single_mode(single_mode), .mode_8086(mode_8086), .auto_eoi(auto_eoi),
    .buf_master(buf_master), .buf_mode(buf_mode), .nested_mode(nested_mode),
    .imr(imr), .smm(smm), .cmd_valid(cmd_valid), .cmd_rotate(cmd_rotate),
    .cmd_specific(cmd_specific), .cmd_eoi(cmd_eoi), .cmd_level(cmd_level)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic put(input logic odd, input logic [7:0] d);
    @(negedge clk); cs = 1; wr = 1; a0 = odd; din = d;
    @(negedge clk); cs = 0; wr = 0;
  endtask

  task automatic get(input logic odd, output logic [7:0] v);
    @(negedge clk); cs = 1; rd = 1; a0 = odd;
    #1 v = dout;
    @(negedge clk); cs = 0; rd = 0;
  endtask

  function automatic logic [7:0] exp_poll(input logic [7:0] pend);
    if (pend == 0) return 8'h00;
    for (int i = 0; i < 8; i++) if (pend[i]) return 8'h80 | 8'(i);
    return 8'h00;
  endfunction

  task automatic t_reset();
    logic [7:0] v;
    chk("R1 init_done", init_done, 0);
    chk("R1 config", {vec_base, cascade_word, trig_level, spacing4, single_mode,
        mode_8086, auto_eoi, buf_master, buf_mode, nested_mode}, 0);
    chk("R1 imr/smm/cmd", {imr, smm, cmd_valid}, 0);
    irr = 8'h5A; isr = 8'hC3;
    get(0, v); chk("R1 even read irr", v, 8'h5A);
  endtask

  task automatic t_uninit();
    put(0, 8'h20); chk("R6 no cmd uninit", cmd_valid, 0);
    put(1, 8'hFF); chk("R6 odd uninit imr", imr, 0);
    chk("R6 still uninit", init_done, 0);
  endtask

  task automatic t_single_icw4();
    put(0, 8'h1B);
    chk("R3 fields", {trig_level, spacing4, single_mode}, 3'b101);
    chk("R2 not done", init_done, 0);
    put(0, 8'h20); chk("R6 cmd during setup", cmd_valid, 0);
    put(1, 8'h40);
    chk("R4 vec", vec_base, 8'h40);
    chk("R4 waits fourth", init_done, 0);
    put(1, 8'h1F);
    chk("R5 fourth fields", {nested_mode, buf_mode, buf_master, auto_eoi, mode_8086}, 5'h1F);
    chk("R4 done", init_done, 1);
    chk("R4 no cascade", cascade_word, 0);
  endtask

  task automatic t_cascade_no4();
    put(0, 8'h10);
    chk("R2 restart clears fourth", {nested_mode, mode_8086}, 0);
    put(1, 8'h08);
    chk("R4 cascade wait", init_done, 0);
    put(1, 8'h04);
    chk("R4 cascade word", cascade_word, 8'h04);
    chk("R4 cascade done", init_done, 1);
    chk("R5 skipped zero", {nested_mode, buf_mode, buf_master, auto_eoi, mode_8086}, 0);
    chk("R3 edge/8", {trig_level, spacing4, single_mode}, 0);
  endtask

  task automatic t_cascade_4();
    put(0, 8'h15); put(1, 8'h70);
    chk("R3 spacing4", spacing4, 1);
    put(1, 8'h02);
    chk("R4 after cascade waits fourth", init_done, 0);
    put(1, 8'h01);
    chk("R5 mode_8086", {auto_eoi, mode_8086}, 2'b01);
    chk("R4 vec/casc", {vec_base, cascade_word}, 16'h7002);
    chk("R4 done", init_done, 1);
  endtask

  task automatic t_restart();
    put(0, 8'h13); put(1, 8'h20);
    put(0, 8'h12);
    chk("R2 mid restart", {init_done, vec_base}, 0);
    put(1, 8'h88);
    chk("R2 resumes", {init_done, vec_base, mode_8086}, {1'b1, 8'h88, 1'b0});
    put(1, 8'h3C); put(0, 8'h68);
    put(0, 8'h12);
    chk("R2 restart clears imr/smm", {imr, smm}, 0);
    put(1, 8'h01);
  endtask

  task automatic t_ocw1();
    logic [7:0] v;
    put(1, 8'hA5); chk("R7 imr", imr, 8'hA5);
    get(1, v); chk("R11 odd read", v, 8'hA5);
  endtask

  task automatic t_ocw2();
    put(0, 8'h63);
    chk("R8 pulse", {cmd_valid, cmd_rotate, cmd_specific, cmd_eoi, cmd_level}, {4'b1011, 3'd3});
    @(negedge clk); chk("R8 one cycle", cmd_valid, 0);
    put(0, 8'hA7);
    chk("R8 rotate", {cmd_valid, cmd_rotate, cmd_specific, cmd_eoi, cmd_level}, {4'b1101, 3'd7});
  endtask

  task automatic t_ocw3();
    logic [7:0] v;
    irr = 8'h3C; isr = 8'h81;
    put(0, 8'h0B); get(0, v); chk("R9 isr", v, 8'h81);
    put(0, 8'h08); get(0, v); chk("R9 kept", v, 8'h81);
    put(0, 8'h0A); get(0, v); chk("R9 irr", v, 8'h3C);
    put(0, 8'h68); chk("R10 smm on", smm, 1);
    put(0, 8'h28); chk("R10 kept", smm, 1);
    put(0, 8'h48); chk("R10 smm off", smm, 0);
  endtask

  task automatic t_poll();
    logic [7:0] v;
    put(1, 8'h05); irr = 8'h0D;
    put(0, 8'h0C);
    get(1, v); chk("R12 odd keeps poll", v, 8'h05);
    get(0, v); chk("R12 poll byte", v, exp_poll(irr & ~8'h05));
    get(0, v); chk("R12 poll cleared", v, 8'h0D);
    irr = 8'h05; put(0, 8'h0C);
    get(0, v); chk("R12 none pending", v, exp_poll(irr & ~8'h05));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_uninit();
    t_single_icw4();
    t_cascade_no4();
    t_cascade_4();
    t_restart();
    t_ocw1();
    t_ocw2();
    t_ocw3();
    t_poll();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog R1..all actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule